// File: doc/BRIEF.md
# Four-Lane Serial-to-Parallel Column Driver Core

This block turns four serial bit streams into a 32-bit parallel word for a display column driver. Each of the four lanes holds an 8-stage shift register. All lanes share one clock, and each lane takes one new bit from its own serial input on every rising edge. A direction input picks the shift direction. Forward shifting moves data toward higher stage numbers, and reverse shifting moves it toward lower ones. Each lane also presents its far end stage on a cascade output, so several cores can be chained on the same clock.

A transfer enable moves the shift register contents into a bank of output latches. While the enable is high the latches follow the shift registers. While it is low they keep their value, and shifting carries on underneath them. The latched word then passes through output gating before it reaches the registered parallel output. The gating has three controls: a blanking control for each lane, a global chip enable, and a polarity control. The polarity control also inverts the forced levels.

Reset is synchronous and active high. All outputs are registered. Stage s of lane l (s counted 1 to 8, lane A = 0) appears on par_out bit l*8 + s - 1.

Top module: `s2p_driver`

## Requirements
- R1: A clock edge with rst high clears every shift stage, every latch and par_out to 0, so ser_out reads 0 afterwards.
- R2: With shift_up = 1 at an edge, each lane's ser_in bit enters stage 1 and every stage n moves to n+1. A single 1 followed by seven 0s leaves the lane's par_out byte at 8'h80.
- R3: With shift_up = 0 at an edge, ser_in enters stage 8 and every stage n moves to n-1. A single 1 followed by seven 0s leaves the lane byte at 8'h01.
- R4: ser_out of a lane shows stage 8 while shift_up = 1 and stage 1 while shift_up = 0, taken from the stored stages. The four lanes shift independently on one clock.
- R5: xfer_en has no effect on shifting: ser_out follows the same sequence whether xfer_en is high or low.
- R6: At an edge with xfer_en = 1, the latches take the shift register contents produced by that edge, and par_out reflects them after the same edge.
- R7: While xfer_en = 0, the latches hold their value. With the gating inputs constant, par_out does not change however many bits are shifted.
- R8: par_out is registered. It reflects chip_en, lane_en and true_pol as sampled at the edge that updates it.
- R9: With chip_en = 1 and all lane_en bits = 1, par_out equals the latches when true_pol = 1 and their inverse when true_pol = 0.
- R10: With chip_en = 0, all 32 bits of par_out equal ~true_pol, whatever the data and lane_en.
- R11: With chip_en = 1 and lane_en[l] = 0, the 8 bits of lane l equal ~true_pol, and the other lanes show their gated latch data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared shift and output clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_up | input | 1 | 1: shift toward stage 8, 0: toward stage 1 |
| ser_in | input | 4 | Serial input, one bit per lane (bit 0 = lane A) |
| xfer_en | input | 1 | Level transfer enable for the output latches |
| lane_en | input | 4 | Per-lane enable, 0 blanks the lane |
| chip_en | input | 1 | Global enable, 0 forces all outputs |
| true_pol | input | 1 | 1: true data, 0: inverted data and forced levels |
| ser_out | output | 4 | Cascade output of each lane's far end stage |
| par_out | output | 32 | Registered gated parallel word |

## Verification
The bench loads a lone marker bit in both directions. A core that reversed its stage order or lost a stage would put the marker in the wrong bit or drop it. Shifting continues while transfer is low. A latch that leaked would change par_out, and a latch that stalled the shifter would freeze ser_out. All 64 combinations of lane enable, chip enable and polarity are swept against a model. This catches a force that ignores polarity, blanking that spills into other lanes, and chip enable losing its priority over blanking. A reset applied after data has been loaded shows whether any stage or latch survives it.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  typedef enum logic {SHIFT_DOWN = 1'b0, SHIFT_UP = 1'b1} shift_dir_e;

  // enabled data passes, any disable forces the low level, then polarity maps it
  function automatic logic gate_bit(input logic d, input logic lane_on,
                                    input logic chip_on, input logic pol);
    return (d & lane_on & chip_on) ~^ pol;
  endfunction
endpackage

// File: rtl/s2p_lane.sv
module s2p_lane #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_up,
  input  logic             ser_in,
  output logic [DEPTH-1:0] stg_nxt,
  output logic             ser_out
);
  import s2p_pkg::*;

  logic [DEPTH-1:0] stg_q;

  always_comb begin
    if (shift_dir_e'(shift_up) == SHIFT_UP) stg_nxt = {stg_q[DEPTH-2:0], ser_in};
    else                                     stg_nxt = {ser_in, stg_q[DEPTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) stg_q <= '0;
    else     stg_q <= stg_nxt;
  end

  assign ser_out = shift_up ? stg_q[DEPTH-1] : stg_q[0];
endmodule

// File: rtl/s2p_latch_gate.sv
module s2p_latch_gate #(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         xfer_en,
  input  logic [LANES-1:0][DEPTH-1:0]  stg_nxt,
  input  logic [LANES-1:0]             lane_en,
  input  logic                         chip_en,
  input  logic                         true_pol,
  output logic [LANES*DEPTH-1:0]       par_out
);
  import s2p_pkg::*;

  localparam int W = LANES * DEPTH;

  logic [LANES-1:0][DEPTH-1:0] lat_q;
  logic [LANES-1:0][DEPTH-1:0] src;
  logic [W-1:0]                gated;

  assign src = xfer_en ? stg_nxt : lat_q;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < DEPTH; s++)
        gated[l*DEPTH+s] = gate_bit(src[l][s], lane_en[l], chip_en, true_pol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= '0;
      par_out <= '0;
    end else begin
      if (xfer_en) lat_q <= stg_nxt;
      par_out <= gated;
    end
  end
endmodule

// File: rtl/s2p_driver.sv
module s2p_driver #(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_up,
  input  logic [LANES-1:0]       ser_in,
  input  logic                   xfer_en,
  input  logic [LANES-1:0]       lane_en,
  input  logic                   chip_en,
  input  logic                   true_pol,
  output logic [LANES-1:0]       ser_out,
  output logic [LANES*DEPTH-1:0] par_out
);
  logic [LANES-1:0][DEPTH-1:0] stg_nxt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    s2p_lane #(.DEPTH(DEPTH)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .shift_up(shift_up),
      .ser_in  (ser_in[l]),
      .stg_nxt (stg_nxt[l]),
      .ser_out (ser_out[l])
    );
  end

  s2p_latch_gate #(.LANES(LANES), .DEPTH(DEPTH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .xfer_en (xfer_en),
    .stg_nxt (stg_nxt),
    .lane_en (lane_en),
    .chip_en (chip_en),
    .true_pol(true_pol),
    .par_out (par_out)
  );
endmodule

// File: rtl/s2p_driver_chk.sv
module s2p_driver_chk #(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   xfer_en,
  input logic [LANES-1:0]       lane_en,
  input logic                   chip_en,
  input logic                   true_pol,
  input logic [LANES-1:0]       ser_out,
  input logic [LANES*DEPTH-1:0] par_out
);
  // R1: the cycle after a reset edge shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (par_out == '0 && ser_out == '0));

  // R10: chip disable forces every bit to the inverse of polarity
  a_r10_chip_force: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> (par_out == {(LANES*DEPTH){~$past(true_pol)}}));

  // R11: a blanked lane is forced to the inverse of polarity
  for (genvar l = 0; l < LANES; l++) begin : g_blank
    a_r11_lane_blank: assert property (@(posedge clk) disable iff (rst)
      (chip_en && !lane_en[l]) |=> (par_out[l*DEPTH +: DEPTH] == {DEPTH{~$past(true_pol)}}));
  end

  // R7: two held cycles with constant pass-through gating keep par_out still
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!xfer_en && chip_en && true_pol && (&lane_en)) ##1
    (!xfer_en && chip_en && true_pol && (&lane_en)) |=> $stable(par_out));
endmodule

bind s2p_driver s2p_driver_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/s2p_driver_tb.sv
`timescale 1ns/1ps
module s2p_driver_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shift_up = 1'b1;
  logic [3:0]  ser_in = '0;
  logic        xfer_en = 1'b1;
  logic [3:0]  lane_en = '1;
  logic        chip_en = 1'b1;
  logic        true_pol = 1'b1;
  logic [3:0]  ser_out;
  logic [31:0] par_out;

  int n_vec = 0;
  int n_bad = 0;

  logic [3:0][7:0] m_sr  = '0;
  logic [3:0][7:0] m_lat = '0;
  logic [31:0]     m_out = '0;

  always #5 clk = ~clk;

  s2p_driver u_dut (.*);

  task automatic step();
    logic [3:0][7:0] nx;
    logic [3:0][7:0] sv;
    @(posedge clk);
    if (rst) begin
      m_sr = '0; m_lat = '0; m_out = '0;
    end else begin
      for (int l = 0; l < 4; l++)
        nx[l] = shift_up ? {m_sr[l][6:0], ser_in[l]} : {ser_in[l], m_sr[l][7:1]};
      if (xfer_en) m_lat = nx;
      sv = m_lat;
      for (int l = 0; l < 4; l++)
        for (int s = 0; s < 8; s++)
          m_out[l*8+s] = (sv[l][s] & lane_en[l] & chip_en) ~^ true_pol;
      m_sr = nx;
    end
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    logic [3:0] exp_so;
    for (int l = 0; l < 4; l++) exp_so[l] = shift_up ? m_sr[l][7] : m_sr[l][0];
    n_vec++;
    if (par_out !== m_out || ser_out !== exp_so) begin
      n_bad++;
      $display("FAIL %s: par_out=%h ser_out=%b expected par_out=%h ser_out=%b",
               tag, par_out, ser_out, m_out, exp_so);
    end
  endtask

  task automatic check_val(input string tag, input logic [31:0] exp);
    n_vec++;
    if (par_out !== exp) begin
      n_bad++;
      $display("FAIL %s: par_out=%h expected %h", tag, par_out, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    check("R1 reset state");
    check_val("R1 reset zero", 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_marker(input logic up);
    shift_up = up; xfer_en = 1'b1; lane_en = '1; chip_en = 1'b1; true_pol = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser_in = (i == 0) ? 4'b1111 : 4'b0000;
      step();
      check(up ? "R2 forward shift" : "R3 reverse shift");
    end
    check_val(up ? "R2 marker at stage 8" : "R3 marker at stage 1",
              up ? 32'h80808080 : 32'h01010101);
    n_vec++;
    if (ser_out !== 4'b1111) begin
      n_bad++;
      $display("FAIL R4: ser_out=%b expected %b", ser_out, 4'b1111);
    end
  endtask

  task automatic t_lanes(input logic up);
    logic [3:0][7:0] pat;
    pat = {8'h3C, 8'hA5, 8'h0F, 8'hD2};
    shift_up = up; xfer_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      for (int l = 0; l < 4; l++) ser_in[l] = pat[l][i];
      step();
      check("R4 independent lanes");
    end
  endtask

  task automatic t_hold();
    logic [31:0] held;
    held = par_out;
    xfer_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      ser_in = 4'(i * 5 + 3);
      shift_up = (i < 3);
      step();
      check("R5 shift under held latch");
      check_val("R7 latch held", held);
    end
    xfer_en = 1'b1; ser_in = 4'b1010;
    step();
    check("R6 transfer after hold");
  endtask

  task automatic t_gating();
    xfer_en = 1'b0;
    for (int c = 0; c < 64; c++) begin
      lane_en  = c[3:0];
      chip_en  = c[4];
      true_pol = c[5];
      ser_in   = 4'(c);
      step();
      if (!chip_en) check("R10 chip force");
      else if (lane_en != 4'hF) check("R11 lane blank");
      else check(true_pol ? "R9 true data" : "R9 inverted data");
    end
    lane_en = '1; chip_en = 1'b1; true_pol = 1'b0;
    step();
    check("R8 registered gating");
  endtask

  task automatic t_reset_loaded();
    xfer_en = 1'b1; true_pol = 1'b1; ser_in = 4'hF;
    step(); step();
    rst = 1'b1; step();
    check_val("R1 reset after load", 32'h0);
    check("R1 reset cascade");
    rst = 1'b0;
    step();
    check("R1 resume after reset");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_marker(1'b1);
    t_marker(1'b0);
    t_lanes(1'b1);
    t_lanes(1'b0);
    t_hold();
    t_gating();
    t_reset_loaded();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule